// File: doc/BRIEF.md
# CSR Privilege Access Checker

This unit stands between the instruction pipeline and a processor's control/status register file. Each cycle it may receive one register access: a 12-bit register address, an operation (read, write, bit-set or bit-clear), the current privilege level, a debug-mode flag and the write operand. It decides whether the access is allowed. There are three rules. The first compares the current privilege level with the minimum level the register requires. The second is a fixed override table that can raise the minimum level of chosen security-sensitive registers, such as the machine exception PC. The third stops any modification of read-only registers. A window of debug-only addresses is open only while debug mode is active.

A permitted access is passed to the register file one cycle later, with a write enable that is high only when the operation really modifies the register. The read data is passed back. A refused access never reaches the register file. In its place the unit raises a one-cycle illegal-instruction pulse together with the faulting address for the trap logic, and returns zero as the read data. No address is exempt from the check.

Top module: `csr_access_guard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rsp_valid`, `exc_valid` and `rf_we` are low and `rsp_rdata` is zero.
- R2: A request sampled at a rising edge gives `rsp_valid` high for exactly one cycle after that edge. `exc_valid` is high in that same cycle only if the request was refused, and `exc_addr` then holds the request address.
- R3: Privilege codes are 0 = user, 1 = supervisor, 2 = hypervisor, 3 = machine. Address bits [9:8] give a register's minimum level. Without debug mode, an access is refused when the current level is below the minimum.
- R4: A fixed override table can raise the minimum level of single addresses but never lower it. The default table sets 0x341 (machine exception PC) and 0x342 to machine, 0x015 to machine and 0x140 to hypervisor.
- R5: A register whose address bits [11:10] are 2'b11 is read-only. Operation codes are 0 = read, 1 = write, 2 = set, 3 = clear. On such a register, a write, or a set or clear with a nonzero operand, is refused. A read, or a set or clear with a zero operand, is allowed if the privilege rules allow it.
- R6: Addresses 0x7B0 to 0x7BF are refused whenever debug mode is inactive, at every privilege level.
- R7: Debug mode passes the privilege check for every address, including the override entries and the debug window. It still refuses modifications of read-only registers.
- R8: A refused request gives `rf_we` low and `rsp_rdata` zero in its response cycle.
- R9: An allowed request gives `rf_we` high exactly for a write, or for a set or clear with a nonzero operand. It forwards the address, operation and operand on `rf_addr`, `rf_op` and `rf_wdata`, and returns the register file's `rf_rdata` on `rsp_rdata`.
- R10: Every one of the 4096 addresses follows rules R3 to R6 with no exemption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| req_wdata | input | 32 | Write value or set/clear mask |
| cur_priv | input | 2 | Current privilege level |
| dbg_mode | input | 1 | Debug mode active |
| rf_rdata | input | 32 | Register file read data for `req_addr` |
| rf_we | output | 1 | Write enable to the register file |
| rf_addr | output | 12 | Forwarded address |
| rf_op | output | 2 | Forwarded operation |
| rf_wdata | output | 32 | Forwarded operand |
| rsp_valid | output | 1 | Response cycle for a request |
| rsp_rdata | output | 32 | Read data, zero on refusal |
| exc_valid | output | 1 | Illegal-instruction pulse |
| exc_addr | output | 12 | Address of the refused access |

## Verification
A fault in the address decode, for example a wrong minimum level or a missed override entry, shows up in the response cycle just one edge after the request. At that point `exc_valid` has the wrong value and `rf_we` or `rsp_rdata` are either let through or wrongly blocked. A sweep of every address against every privilege level, with the operation and operand zero-ness varied, therefore exposes a single bad address within two cycles of it being issued. A refusal that is not cleared in time would show as `exc_valid` still high in the idle cycle that follows.

// File: rtl/csr_guard_pkg.sv
package csr_guard_pkg;

  typedef enum logic [1:0] {
    PRV_U = 2'd0,
    PRV_S = 2'd1,
    PRV_H = 2'd2,
    PRV_M = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    CSR_RD  = 2'd0,
    CSR_WR  = 2'd1,
    CSR_SET = 2'd2,
    CSR_CLR = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic [1:0] min_priv;
    logic       read_only;
    logic       dbg_only;
  } csr_attr_t;

endpackage

// File: rtl/csr_attr_decode.sv
module csr_attr_decode
  import csr_guard_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int NUM_OVR       = 4,
  parameter logic [NUM_OVR-1:0][ADDR_W-1:0] OVR_ADDR = {12'h140, 12'h015, 12'h342, 12'h341},
  parameter logic [NUM_OVR-1:0][1:0]        OVR_PRIV = {2'd2, 2'd3, 2'd3, 2'd3},
  parameter logic [ADDR_W-1:0] DBG_BASE = 12'h7B0,
  parameter int DBG_SPAN_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_attr_t         attr
);
  localparam int PRIV_LSB = ADDR_W - 4;
  localparam int RO_LSB   = ADDR_W - 2;

  logic [NUM_OVR-1:0]      hit;
  logic [NUM_OVR-1:0][1:0] ovr_lvl;

  // one comparator per protected entry
  for (genvar g = 0; g < NUM_OVR; g++) begin : g_ovr
    assign hit[g]     = (addr == OVR_ADDR[g]);
    assign ovr_lvl[g] = hit[g] ? OVR_PRIV[g] : 2'd0;
  end

  always_comb begin
    attr.min_priv = addr[PRIV_LSB +: 2];
    // entries may only raise the level
    for (int i = 0; i < NUM_OVR; i++) begin
      if (ovr_lvl[i] > attr.min_priv) attr.min_priv = ovr_lvl[i];
    end
    attr.read_only = &addr[RO_LSB +: 2];
    attr.dbg_only  = (addr[ADDR_W-1:DBG_SPAN_LOG2] == DBG_BASE[ADDR_W-1:DBG_SPAN_LOG2]);
  end

endmodule

// File: rtl/csr_policy_eval.sv
module csr_policy_eval
  import csr_guard_pkg::*;
(
  input  csr_attr_t attr,
  input  csr_op_e   op,
  input  priv_e     priv,
  input  logic      dbg,
  input  logic      mask_nz,
  output logic      legal,
  output logic      wr_intent
);
  logic priv_ok, range_ok, ro_ok;

  always_comb begin
    wr_intent = (op == CSR_WR) || (((op == CSR_SET) || (op == CSR_CLR)) && mask_nz);
    priv_ok   = dbg || (priv >= attr.min_priv);
    range_ok  = dbg || !attr.dbg_only;
    ro_ok     = !(attr.read_only && wr_intent);
    legal     = priv_ok && range_ok && ro_ok;
  end

endmodule

// File: rtl/csr_access_guard.sv
module csr_access_guard
  import csr_guard_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int XLEN    = 32,
  parameter int NUM_OVR = 4,
  parameter logic [NUM_OVR-1:0][ADDR_W-1:0] OVR_ADDR = {12'h140, 12'h015, 12'h342, 12'h341},
  parameter logic [NUM_OVR-1:0][1:0]        OVR_PRIV = {2'd2, 2'd3, 2'd3, 2'd3},
  parameter logic [ADDR_W-1:0] DBG_BASE = 12'h7B0,
  parameter int DBG_SPAN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic [1:0]        cur_priv,
  input  logic              dbg_mode,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [1:0]        rf_op,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic              exc_valid,
  output logic [ADDR_W-1:0] exc_addr
);
  csr_attr_t attr;
  logic      legal, wr_intent;

  csr_attr_decode #(
    .ADDR_W(ADDR_W), .NUM_OVR(NUM_OVR), .OVR_ADDR(OVR_ADDR), .OVR_PRIV(OVR_PRIV),
    .DBG_BASE(DBG_BASE), .DBG_SPAN_LOG2(DBG_SPAN_LOG2)
  ) u_dec (
    .addr(req_addr),
    .attr(attr)
  );

  csr_policy_eval u_pol (
    .attr     (attr),
    .op       (csr_op_e'(req_op)),
    .priv     (priv_e'(cur_priv)),
    .dbg      (dbg_mode),
    .mask_nz  (|req_wdata),
    .legal    (legal),
    .wr_intent(wr_intent)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we     <= 1'b0;
      rf_addr   <= '0;
      rf_op     <= 2'd0;
      rf_wdata  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      exc_valid <= 1'b0;
      exc_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      exc_valid <= req_valid && !legal;
      rf_we     <= req_valid && legal && wr_intent;
      rsp_rdata <= (req_valid && legal) ? rf_rdata : '0;
      if (req_valid && legal) begin
        rf_addr  <= req_addr;
        rf_op    <= req_op;
        rf_wdata <= req_wdata;
      end
      if (req_valid && !legal) exc_addr <= req_addr;
    end
  end

endmodule

// File: rtl/csr_access_guard_chk.sv
module csr_access_guard_chk #(
  parameter int ADDR_W = 12,
  parameter int XLEN   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_op,
  input logic [1:0]        cur_priv,
  input logic              dbg_mode,
  input logic              rf_we,
  input logic              rsp_valid,
  input logic [XLEN-1:0]   rsp_rdata,
  input logic              exc_valid
);
  logic [1:0] lvl_bits, ro_bits;
  assign lvl_bits = req_addr[ADDR_W-3 -: 2];
  assign ro_bits  = req_addr[ADDR_W-1 -: 2];

  AST_EXC_HAS_RSP: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> rsp_valid); // R2

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rsp_valid == $past(req_valid))); // R2

  AST_EXC_NO_WE: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> !rf_we); // R8

  AST_EXC_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (rsp_rdata == '0)); // R8

  AST_LOWER_PRIV_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_valid && !dbg_mode && (cur_priv < lvl_bits))) |-> exc_valid); // R3

  AST_RO_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_valid && (ro_bits == 2'b11) && (req_op == 2'd1))) |-> (exc_valid && !rf_we)); // R5

  AST_MEPC_GUARD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_valid && !dbg_mode && (req_addr == 12'h341) && (cur_priv != 2'd3))) |-> exc_valid); // R4

  AST_DBG_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_valid && !dbg_mode && (req_addr[ADDR_W-1:4] == 8'h7B))) |-> exc_valid); // R6

endmodule

bind csr_access_guard csr_access_guard_chk #(.ADDR_W(ADDR_W), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op),
  .cur_priv(cur_priv), .dbg_mode(dbg_mode), .rf_we(rf_we), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .exc_valid(exc_valid)
);

// File: tb/csr_access_guard_test.sv
module csr_access_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  cur_priv = '0;
  logic        dbg_mode = 1'b0;
  logic [31:0] rf_rdata;
  logic        rf_we, rsp_valid, exc_valid;
  logic [11:0] rf_addr, exc_addr;
  logic [1:0]  rf_op;
  logic [31:0] rf_wdata, rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  // register file model: data tagged with its address
  assign rf_rdata = {20'hC0DE0, req_addr};

  csr_access_guard uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op),
    .req_wdata(req_wdata), .cur_priv(cur_priv), .dbg_mode(dbg_mode), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_op(rf_op), .rf_wdata(rf_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .exc_valid(exc_valid), .exc_addr(exc_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_level(input logic [11:0] a);
    logic [1:0] l;
    l = a[9:8];
    if ((a == 12'h341 || a == 12'h342 || a == 12'h015) && l < 2'd3) l = 2'd3;
    if (a == 12'h140 && l < 2'd2) l = 2'd2;
    return l;
  endfunction

  function automatic bit ref_writes(input logic [1:0] op, input logic [31:0] d);
    return (op == 2'd1) || (op >= 2'd2 && d != 0);
  endfunction

  function automatic bit ref_legal(input logic [11:0] a, input logic [1:0] op,
                                   input logic [1:0] p, input bit dbg, input logic [31:0] d);
    if (!dbg && a >= 12'h7B0 && a <= 12'h7BF) return 0;
    if (!dbg && p < ref_level(a)) return 0;
    if (a[11:10] == 2'b11 && ref_writes(op, d)) return 0;
    return 1;
  endfunction

  // drive one request, check its response one edge later
  task automatic do_req(input logic [11:0] a, input logic [1:0] op, input logic [1:0] p,
                        input bit dbg, input logic [31:0] d, input string req);
    bit lg, wr;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_op = op; cur_priv = p; dbg_mode = dbg; req_wdata = d;
    lg = ref_legal(a, op, p, dbg, d);
    wr = lg && ref_writes(op, d);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R2", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(exc_valid == !lg, req, $sformatf("exc_valid a=%h op=%0d p=%0d dbg=%0d", a, op, p, dbg),
        32'(exc_valid), 32'(!lg));
    chk(rf_we == wr, lg ? "R9" : "R8", $sformatf("rf_we a=%h op=%0d", a, op), 32'(rf_we), 32'(wr));
    chk(rsp_rdata == (lg ? {20'hC0DE0, a} : 32'h0), lg ? "R9" : "R8", "rsp_rdata",
        rsp_rdata, lg ? {20'hC0DE0, a} : 32'h0);
    if (!lg) chk(exc_addr == a, "R2", "exc_addr", 32'(exc_addr), 32'(a));
    if (lg) begin
      chk(rf_addr == a && rf_op == op, "R9", "rf_addr/op", {18'd0, rf_op, rf_addr}, {18'd0, op, a});
      chk(rf_wdata == d, "R9", "rf_wdata", rf_wdata, d);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    req_valid = 1'b1; req_addr = 12'h341; req_op = 2'd1; cur_priv = 2'd0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !exc_valid && !rf_we && rsp_rdata == 0, "R1", "outputs in reset",
        {rsp_valid, exc_valid, rf_we}, 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && !exc_valid && !rf_we, "R1", "outputs after reset",
        {rsp_valid, exc_valid, rf_we}, 32'd0);
  endtask

  task automatic t_priv_sweep(); // R10 full address space vs R3, R4, R5, R6
    for (int a = 0; a < 4096; a++) begin
      for (int p = 0; p < 4; p++) begin
        do_req(12'(a), 2'((a + p) % 4), 2'(p), 1'b0, (a[1] ? 32'h0000_0005 : 32'h0), "R10");
      end
    end
  endtask

  task automatic t_debug_sweep(); // R7 debug passes privilege, keeps read-only
    for (int a = 0; a < 4096; a++) begin
      do_req(12'(a), 2'(a % 4), 2'd0, 1'b1, 32'h1, "R7");
    end
  endtask

  task automatic t_mepc(); // R4
    for (int p = 0; p < 3; p++) begin
      do_req(12'h341, 2'd0, 2'(p), 1'b0, 32'h0, "R4");
      do_req(12'h341, 2'd1, 2'(p), 1'b0, 32'h1234, "R4");
    end
    do_req(12'h341, 2'd1, 2'd3, 1'b0, 32'h8000_0000, "R4");
    do_req(12'h015, 2'd0, 2'd2, 1'b0, 32'h0, "R4");
    do_req(12'h140, 2'd0, 2'd1, 1'b0, 32'h0, "R4");
    do_req(12'h140, 2'd0, 2'd2, 1'b0, 32'h0, "R4");
  endtask

  task automatic t_readonly(); // R5
    do_req(12'hF11, 2'd0, 2'd3, 1'b0, 32'hFFFF_FFFF, "R5");
    do_req(12'hF11, 2'd1, 2'd3, 1'b0, 32'h0, "R5");
    do_req(12'hF11, 2'd2, 2'd3, 1'b0, 32'h0, "R5");
    do_req(12'hF11, 2'd3, 2'd3, 1'b0, 32'h1, "R5");
    do_req(12'hC00, 2'd3, 2'd0, 1'b0, 32'h0, "R5");
    do_req(12'hC00, 2'd1, 2'd0, 1'b1, 32'h0, "R5");
  endtask

  task automatic t_dbg_window(); // R6
    do_req(12'h7B0, 2'd0, 2'd3, 1'b0, 32'h0, "R6");
    do_req(12'h7BF, 2'd1, 2'd3, 1'b0, 32'h7, "R6");
    do_req(12'h7B2, 2'd1, 2'd0, 1'b1, 32'h7, "R6");
    do_req(12'h7C0, 2'd0, 2'd3, 1'b0, 32'h0, "R6");
  endtask

  task automatic t_pulse(); // R2 refusal lasts one cycle
    do_req(12'h300, 2'd0, 2'd0, 1'b0, 32'h0, "R2");
    @(negedge clk);
    chk(!exc_valid && !rsp_valid, "R2", "idle after refusal", {rsp_valid, exc_valid}, 32'd0);
    do_req(12'h001, 2'd2, 2'd0, 1'b0, 32'h3, "R9");
    do_req(12'h001, 2'd2, 2'd0, 1'b0, 32'h0, "R9");
  endtask

  initial begin
    t_reset();
    t_mepc();
    t_readonly();
    t_dbg_window();
    t_pulse();
    t_priv_sweep();
    t_debug_sweep();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule